// File: doc/BRIEF.md
# Serial Flash Write Protection Guard

This block sits beside the command decoder of a serial flash device and decides, one request at a time, whether a status-register write, a whole-array erase, or a program or erase aimed at one sector may go ahead. It owns the protection state: a three-bit protection level, a bit that chooses the end of the array the protected region grows from, and a lock bit. The lock bit, together with a low level on the write-protect pin, freezes that state.

The decoder presents a request for one cycle. The request carries an operation class, a target sector, the proposed new status byte and the write-protect pin level. In the next cycle the block raises a response strobe together with a grant flag. When a status write is granted, the new protection state shows on the status output in that same cycle. A small response state machine has three states. `ST_IDLE` means no response. `ST_GRANT` means the previous request was allowed. `ST_DENY` means it was refused. On every clock it takes one of three transitions: `T_ACCEPT` on a granted request, `T_REFUSE` on a refused request, and `T_QUIET` when there is no request.

Top module: `wp_guard`

## Requirements
- R1: After reset the status output is 0x00, the response strobe is low and the grant flag is low.
- R2: A request with `req_i` high in one cycle gives `rsp_vld_o` high in the next cycle only. A cycle without a request gives no response in the following cycle.
- R3: A whole-array erase (class 1) is granted only when the protection level (status bits 4:2) is 0.
- R4: A granted status write (class 0) copies bits 7, 5 and 4:2 of `wdata_i` into the status register. The new value shows on `stat_o` in the cycle after the request. All other status bits read 0.
- R5: When the lock bit (status bit 7) is 1 and `wp_ni` is low, a status write is refused and `stat_o` keeps its value.
- R6: With protection level 0, every sector program or erase (class 2) is granted.
- R7: With protection level 7, every sector request is refused, whatever the direction bit (status bit 5) says.
- R8: With a level c from 1 to 6 and the direction bit at 0, the top min(2^(c-1), 32) sectors, counting down from sector 31, are protected, and requests to them are refused. Requests to the other sectors are granted.
- R9: With a level c from 1 to 6 and the direction bit at 1, the bottom min(2^(c-1), 32) sectors, counting up from sector 0, are protected and refused. Requests to the other sectors are granted.
- R10: With the lock bit at 1 and `wp_ni` high, status writes are granted, including writes that clear the lock bit.
- R11: A request of class 3 is always refused and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| cls_i | input | 2 | Operation class: 0 status write, 1 whole-array erase, 2 sector program/erase, 3 reserved |
| sect_i | input | 5 | Target sector for class 2 |
| wdata_i | input | 8 | Proposed status byte for class 0 |
| wp_ni | input | 1 | Write-protect pin level, low asserts protection |
| stat_o | output | 8 | Status: bit 7 lock, bit 5 direction, bits 4:2 protection level |
| rsp_vld_o | output | 1 | Response strobe, one cycle after a request |
| rsp_ok_o | output | 1 | Grant flag, valid while the response strobe is high |

## Verification
The frozen state is the hardest case to reach from the ports. The bench must first set the lock bit with the pin released, then pull the pin low, then try to rewrite the status. After that it must release the pin again to show that the lock was only conditional. Directed sequences walk through this order and also check the region edges for every level in both directions. Random requests with a random pin level then move through all levels and lock combinations. A bench model tracks the status and computes each expected grant.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef enum logic [1:0] {
        OP_STAT_WR = 2'd0,
        OP_BULK    = 2'd1,
        OP_SECTOR  = 2'd2,
        OP_RSVD    = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } rsp_st_e;

    localparam int STAT_W   = 8;
    localparam int LOCK_POS = 7;
    localparam int DIR_POS  = 5;
    localparam int LVL_LO   = 2;

endpackage

// File: rtl/wpg_region.sv
module wpg_region #(
    parameter int SECT_W = 5,
    parameter int LVL_W  = 3
) (
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              dir_i,
    input  logic [SECT_W-1:0] sect_i,
    output logic              prot_o
);
    localparam int NUM_SECT = 1 << SECT_W;
    localparam int LVL_MAX  = (1 << LVL_W) - 1;

    logic [SECT_W:0] span;
    logic [SECT_W:0] sect_ext;

    assign sect_ext = {1'b0, sect_i};

    always_comb begin
        if (int'(lvl_i) == 0) begin
            span = '0;
        end else if (int'(lvl_i) - 1 >= SECT_W) begin
            span = (SECT_W+1)'(NUM_SECT);
        end else begin
            span = (SECT_W+1)'(1) << (lvl_i - LVL_W'(1));
        end
    end

    always_comb begin
        if (int'(lvl_i) == LVL_MAX) begin
            prot_o = 1'b1;
        end else if (span == '0) begin
            prot_o = 1'b0;
        end else if (dir_i) begin
            prot_o = sect_ext < span;
        end else begin
            prot_o = sect_ext >= ((SECT_W+1)'(NUM_SECT) - span);
        end
    end

endmodule

// File: rtl/wpg_fsm.sv
module wpg_fsm
    import wpg_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  op_cls_e          cls_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             frozen_i,
    input  logic             sect_prot_i,
    output logic             commit_o,
    output logic             rsp_vld_o,
    output logic             rsp_ok_o
);
    rsp_st_e st_q, st_d;
    logic    ok;

    always_comb begin
        unique case (cls_i)
            OP_STAT_WR: ok = !frozen_i;
            OP_BULK:    ok = (lvl_i == '0);
            OP_SECTOR:  ok = !sect_prot_i;
            OP_RSVD:    ok = 1'b0;
            default:    ok = 1'b0;
        endcase
    end

    always_comb begin
        if (!req_i) begin
            st_d = ST_IDLE;
        end else if (ok) begin
            st_d = ST_GRANT;
        end else begin
            st_d = ST_DENY;
        end
    end

    assign commit_o = req_i && ok && (cls_i == OP_STAT_WR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:  begin rsp_vld_o = 1'b0; rsp_ok_o = 1'b0; end
            ST_GRANT: begin rsp_vld_o = 1'b1; rsp_ok_o = 1'b1; end
            ST_DENY:  begin rsp_vld_o = 1'b1; rsp_ok_o = 1'b0; end
            default:  begin rsp_vld_o = 1'b0; rsp_ok_o = 1'b0; end
        endcase
    end

    assert_bulk_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i == OP_BULK && lvl_i != '0) |=> (rsp_vld_o && !rsp_ok_o));

    assert_rsvd_refused_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i == OP_RSVD) |=> !rsp_ok_o);

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wpg_pkg::*;
#(
    parameter int SECT_W = 5,
    parameter int LVL_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [1:0]        cls_i,
    input  logic [SECT_W-1:0] sect_i,
    input  logic [7:0]        wdata_i,
    input  logic              wp_ni,
    output logic [7:0]        stat_o,
    output logic              rsp_vld_o,
    output logic              rsp_ok_o
);
    localparam int LVL_HI = LVL_LO + LVL_W - 1;

    logic             lock_q;
    logic             dir_q;
    logic [LVL_W-1:0] lvl_q;
    logic             frozen;
    logic             sect_prot;
    logic             commit;
    op_cls_e          cls;

    assign cls    = op_cls_e'(cls_i);
    assign frozen = lock_q && !wp_ni;

    wpg_region #(.SECT_W(SECT_W), .LVL_W(LVL_W)) u_region (
        .lvl_i  (lvl_q),
        .dir_i  (dir_q),
        .sect_i (sect_i),
        .prot_o (sect_prot)
    );

    wpg_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req_i),
        .cls_i       (cls),
        .lvl_i       (lvl_q),
        .frozen_i    (frozen),
        .sect_prot_i (sect_prot),
        .commit_o    (commit),
        .rsp_vld_o   (rsp_vld_o),
        .rsp_ok_o    (rsp_ok_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
            dir_q  <= 1'b0;
            lvl_q  <= '0;
        end else if (commit) begin
            lock_q <= wdata_i[LOCK_POS];
            dir_q  <= wdata_i[DIR_POS];
            lvl_q  <= wdata_i[LVL_HI:LVL_LO];
        end
    end

    always_comb begin
        stat_o                = '0;
        stat_o[LOCK_POS]      = lock_q;
        stat_o[DIR_POS]       = dir_q;
        stat_o[LVL_HI:LVL_LO] = lvl_q;
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_vld_o);

    assert_no_stray_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_vld_o);

    assert_frozen_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i == 2'd0 && stat_o[LOCK_POS] && !wp_ni) |=> ($stable(stat_o) && !rsp_ok_o));

    assert_open_array_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i == 2'd2 && stat_o[LVL_HI:LVL_LO] == '0) |=> rsp_ok_o);

    assert_full_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i == 2'd2 && stat_o[LVL_HI:LVL_LO] == '1) |=> !rsp_ok_o);

endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
    localparam int CLK_PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       req_i = 1'b0;
    logic [1:0] cls_i = '0;
    logic [4:0] sect_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wp_ni = 1'b1;
    logic [7:0] stat_o;
    logic       rsp_vld_o;
    logic       rsp_ok_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] m_stat = 8'h00;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    wp_guard u0 (.*);

    function automatic bit exp_prot(input int sec, input int lvl, input bit dir);
        int span;
        if (lvl == 7) return 1;
        if (lvl == 0) return 0;
        span = 2 ** (lvl - 1);
        if (span > 32) span = 32;
        if (dir) return sec < span;
        return sec > 31 - span;
    endfunction

    function automatic bit exp_ok(input int cls, input int sec, input bit wpn);
        int lvl = int'(m_stat[4:2]);
        case (cls)
            0: return !(m_stat[7] && !wpn);
            1: return lvl == 0;
            2: return !exp_prot(sec, lvl, m_stat[5]);
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input string tag, input int cls, input int sec,
                          input logic [7:0] wd, input bit wpn);
        bit ok;
        @(negedge clk_i);
        req_i = 1'b1; cls_i = 2'(cls); sect_i = 5'(sec); wdata_i = wd; wp_ni = wpn;
        ok = exp_ok(cls, sec, wpn);
        if (cls == 0 && ok) m_stat = wd & 8'hBC;
        @(negedge clk_i);
        req_i = 1'b0;
        check({tag, " rsp_vld"}, {7'd0, rsp_vld_o}, 8'd1);
        check({tag, " ok"}, {7'd0, rsp_ok_o}, {7'd0, ok});
        check({tag, " stat"}, stat_o, m_stat);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        repeat (3) @(negedge clk_i);
        check("R1 stat", stat_o, 8'h00);
        check("R1 vld", {7'd0, rsp_vld_o}, 8'd0);
        check("R1 ok", {7'd0, rsp_ok_o}, 8'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R2 quiet", {7'd0, rsp_vld_o}, 8'd0);

        do_req("R3 bulk open", 1, 0, 8'h00, 1);
        do_req("R6 sector open", 2, 31, 8'h00, 1);
        do_req("R4 wr lvl3 top", 0, 0, 8'hFF & 8'h0C, 1);
        @(negedge clk_i);
        check("R2 no rsp after idle", {7'd0, rsp_vld_o}, 8'd0);
        do_req("R8 edge 27", 2, 27, 8'h00, 1);
        do_req("R8 edge 28", 2, 28, 8'h00, 1);
        do_req("R3 bulk denied", 1, 0, 8'h00, 1);
        for (int lv = 1; lv < 8; lv++) begin
            for (int d = 0; d < 2; d++) begin
                do_req("R4 wr lvl", 0, 0, 8'((lv << 2) | (d << 5)), 0);
                for (int s = 0; s < 32; s += 3) do_req(d ? "R9 region" : "R8 region", 2, s, 8'h00, 1);
                do_req("R7 R9 low end", 2, 0, 8'h00, 1);
                do_req("R7 R8 high end", 2, 31, 8'h00, 1);
            end
        end
        do_req("R11 rsvd", 3, 5, 8'hFF, 1);
        do_req("R10 set lock", 0, 0, 8'h88, 1);
        do_req("R5 frozen wr", 0, 0, 8'h00, 0);
        do_req("R5 frozen bulk", 1, 0, 8'h00, 0);
        do_req("R10 unlock", 0, 0, 8'h00, 1);
        do_req("R6 after unlock", 2, 3, 8'h00, 0);

        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(0, 3));
            do_req(c == 0 ? "R4 R5 R10 rand" : (c == 1 ? "R3 rand" :
                   (c == 2 ? "R8 R9 rand" : "R11 rand")),
                   c, int'($urandom_range(0, 31)), 8'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule